// File: doc/BRIEF.md
# Companion GPIO and Control Register Block

This block is a small memory-mapped peripheral that sits on a simple synchronous register bus. It exposes a bank of 16-bit control words to software. These cover an operating mode, a clock divider, a clock control word, a power control word, a fixed status word and three interrupt bookkeeping words. Next to the bank sits a 16-line general-purpose port. Software picks, line by line, whether each line is driven. It then writes a level word, and only the lines set to drive ever reach the output pins.

Every write to the direction word or to the level word triggers one evaluation of the driven vector. Each line whose driven value changed gives a one-cycle strobe, so downstream logic can react to edges without polling. External logic can also force individual level bits through a separate per-line input. That path ignores the direction word and does not start an evaluation. Reads come back one cycle after the request. Any access outside the defined word offsets is flagged for one cycle.

Top module: `gpc_companion`

## Requirements
- R1: After reset, bus_rdata, gpio_out, gpio_chg and bus_unmapped are zero. The status word reads 0x0002 and every other word reads 0x0000.
- R2: Word offsets are: mode 0x000, divider 0x004, status 0x008, power 0x00C, clock control 0x010, interrupt routing 0x014, interrupt mask 0x018, interrupt status 0x01C, direction 0x020, level 0x024 and 0x028. A write stores bits 15:0 of the 32-bit bus_wdata. Bits 31:16 are discarded.
- R3: A write to the power word with bit 7 set stores the data ORed with 0x8040. Any other power write stores the data unchanged.
- R4: The status word is read-only. Writes to offset 0x008 change nothing, and reads keep returning 0x0002.
- R5: A write to 0x024 or 0x028 stores the data ANDed with the current direction word. Both offsets read back that same level word.
- R6: gpio_out equals level AND direction as evaluated at the clock edge of each direction or level write. It holds between such writes. A line whose direction bit is 0 always drives 0.
- R7: In the cycle after a direction or level write, gpio_chg[i] is 1 exactly for the lines whose gpio_out bit toggled. In every other cycle gpio_chg is zero.
- R8: For each line i with ext_we[i] = 1, level bit i takes ext_val[i] at the clock edge, whatever the direction bit. This does not change gpio_out or gpio_chg. When a bus level write happens in the same cycle, the bus value wins.
- R9: Any access to an offset not listed in R2 reads 0x0000 and has no effect on stored state. bus_unmapped is 1 in the cycle after it, and 0 after any mapped access or idle cycle.
- R10: bus_rdata is loaded in the cycle after a read (bus_valid = 1, bus_write = 0). It holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read, qualified by bus_valid |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data; only bits 15:0 are kept |
| ext_we | input | 16 | Per-line enable for external level updates |
| ext_val | input | 16 | Per-line value applied where ext_we is set |
| bus_rdata | output | 16 | Registered read data |
| bus_unmapped | output | 1 | One-cycle flag after an access to an undefined offset |
| gpio_out | output | 16 | Driven line levels (level AND direction) |
| gpio_chg | output | 16 | One-cycle per-line toggle strobe |

## Verification
The assertions assume that bus_valid is a single-cycle strobe with bus_write and bus_addr stable in that cycle. They also assume reset is held across at least one rising edge before anything is checked. The stimulus drives every input just after the falling edge and issues at most one access per cycle. It mixes accesses to the eleven defined offsets with uniformly drawn offsets across the whole window, and it overlaps external level updates with bus level writes on purpose. That overlap exercises the priority rule the level-masking assertion relies on.

// File: rtl/gpc_pkg.sv
// gpc_pkg: shared definitions for the companion GPIO block.
// Assumes word-aligned offsets; word index = byte offset >> 2.
package gpc_pkg;

    localparam int NUM_WORDS = 11;
    localparam int NUM_CTRL  = 7;
    localparam int IDX_W     = 4;

    typedef enum logic [IDX_W-1:0] {
        W_MODE   = 4'd0,
        W_DIV    = 4'd1,
        W_STAT   = 4'd2,
        W_PWR    = 4'd3,
        W_CCTL   = 4'd4,
        W_IROUTE = 4'd5,
        W_IMASK  = 4'd6,
        W_ISTAT  = 4'd7,
        W_DIR    = 4'd8,
        W_LVL_A  = 4'd9,
        W_LVL_B  = 4'd10
    } word_e;

    // Maps a plain control-register slot to its word index.
    function automatic int ctrl_word(input int k);
        case (k)
            0:       return int'(W_MODE);
            1:       return int'(W_DIV);
            2:       return int'(W_PWR);
            3:       return int'(W_CCTL);
            4:       return int'(W_IROUTE);
            5:       return int'(W_IMASK);
            default: return int'(W_ISTAT);
        endcase
    endfunction

endpackage

// File: rtl/gpc_decode.sv
// gpc_decode: turns a byte offset into a one-hot word select.
// Assumes a word lives at offset index*4; anything misaligned or past the
// last word is reported as unmapped. Purely combinational.
module gpc_decode #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]              addr,
    output logic [gpc_pkg::NUM_WORDS-1:0]  sel,
    output logic [gpc_pkg::IDX_W-1:0]      idx,
    output logic                           mapped
);
    import gpc_pkg::*;

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    // Split the offset into word index and alignment bits.
    always_comb begin
        widx    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        mapped  = aligned && (widx < WIDX_W'(NUM_WORDS));
        idx     = mapped ? widx[IDX_W-1:0] : '0;
    end

    // One select line per defined word.
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_sel
        assign sel[g] = mapped && (widx == WIDX_W'(g));
    end

endmodule

// File: rtl/gpc_ctrl_reg.sv
// gpc_ctrl_reg: one writable control word. Optionally, when a trigger bit
// is set in the written data, a fixed mask is ORed into the stored value.
// Assumes the write data is already truncated to the word width.
module gpc_ctrl_reg #(
    parameter int          W        = 16,
    parameter bit          TRIG_EN  = 1'b0,
    parameter int          TRIG_BIT = 0,
    parameter logic [W-1:0] SET_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] next_val;

    // Apply the optional set-on-trigger rule to the incoming value.
    if (TRIG_EN) begin : g_trig
        always_comb next_val = wdata[TRIG_BIT] ? (wdata | SET_MASK) : wdata;
    end else begin : g_plain
        always_comb next_val = wdata;
    end

    // Store on write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= next_val;
    end

endmodule

// File: rtl/gpc_gpio.sv
// gpc_gpio: direction and level words, per-line external level updates,
// and driven-vector evaluation with per-line toggle strobes.
// Assumes at most one of dir_we / lvl_we per cycle. A bus level write
// overrides external updates in the same cycle.
module gpc_gpio #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic             lvl_we,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] ext_we,
    input  logic [LINES-1:0] ext_val,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] lvl_q,
    output logic [LINES-1:0] out_q,
    output logic [LINES-1:0] chg_q
);

    logic [LINES-1:0] dir_n;
    logic [LINES-1:0] lvl_ext;
    logic [LINES-1:0] lvl_n;
    logic [LINES-1:0] drive_n;
    logic             eval;

    // Per-line external level override.
    for (genvar i = 0; i < LINES; i++) begin : g_ext
        assign lvl_ext[i] = ext_we[i] ? ext_val[i] : lvl_q[i];
    end

    // Next direction/level words and the driven vector they produce.
    always_comb begin
        dir_n   = dir_we ? wdata : dir_q;
        lvl_n   = lvl_we ? (wdata & dir_q) : lvl_ext;
        drive_n = lvl_n & dir_n;
        eval    = dir_we | lvl_we;
    end

    // Direction and level storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else begin
            dir_q <= dir_n;
            lvl_q <= lvl_n;
        end
    end

    // Driven vector and toggle strobes, updated only on an evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            chg_q <= '0;
        end else if (eval) begin
            out_q <= drive_n;
            chg_q <= drive_n ^ out_q;
        end else begin
            chg_q <= '0;
        end
    end

endmodule

// File: rtl/gpc_companion.sv
// gpc_companion: top of the companion GPIO register block. It decodes bus
// accesses, holds the control words, forwards direction/level writes to
// the port logic and returns registered read data.
// Assumes single-cycle access strobes and at most one access per cycle.
module gpc_companion #(
    parameter int          ADDR_W   = 12,
    parameter int          BUS_W    = 32,
    parameter int          DATA_W   = 16,
    parameter int          LINES    = 16,
    parameter logic [15:0] STAT_RST = 16'h0002,
    parameter int          PWR_TRIG = 7,
    parameter logic [15:0] PWR_SET  = 16'h8040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [LINES-1:0]  ext_we,
    input  logic [LINES-1:0]  ext_val,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_unmapped,
    output logic [LINES-1:0]  gpio_out,
    output logic [LINES-1:0]  gpio_chg
);
    import gpc_pkg::*;

    logic [NUM_WORDS-1:0] sel;
    logic [IDX_W-1:0]     idx;
    logic                 mapped;
    logic                 wr;
    logic                 rd;
    logic [DATA_W-1:0]    wd;
    logic [DATA_W-1:0]    ctrl_q [NUM_CTRL];
    logic [DATA_W-1:0]    words  [NUM_WORDS];
    logic [LINES-1:0]     dir_q;
    logic [LINES-1:0]     lvl_q;

    // Qualify the access and truncate write data to the word width.
    always_comb begin
        wr = bus_valid & bus_write;
        rd = bus_valid & ~bus_write;
        wd = bus_wdata[DATA_W-1:0];
    end

    gpc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .idx    (idx),
        .mapped (mapped)
    );

    // Plain and power control words; the power word carries the set rule.
    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
        localparam int  WIDX = ctrl_word(k);
        localparam bit  IS_PWR = (WIDX == int'(W_PWR));
        gpc_ctrl_reg #(
            .W        (DATA_W),
            .TRIG_EN  (IS_PWR),
            .TRIG_BIT (PWR_TRIG),
            .SET_MASK (DATA_W'(PWR_SET))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr & sel[WIDX]),
            .wdata (wd),
            .q     (ctrl_q[k])
        );
    end

    gpc_gpio #(.LINES(LINES)) u_gpio (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_we  (wr & sel[W_DIR]),
        .lvl_we  (wr & (sel[W_LVL_A] | sel[W_LVL_B])),
        .wdata   (wd[LINES-1:0]),
        .ext_we  (ext_we),
        .ext_val (ext_val),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .out_q   (gpio_out),
        .chg_q   (gpio_chg)
    );

    // Collect every readable word by index.
    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) words[i] = '0;
        for (int k = 0; k < NUM_CTRL; k++) words[ctrl_word(k)] = ctrl_q[k];
        words[W_STAT]  = DATA_W'(STAT_RST);
        words[W_DIR]   = DATA_W'(dir_q);
        words[W_LVL_A] = DATA_W'(lvl_q);
        words[W_LVL_B] = DATA_W'(lvl_q);
    end

    // Registered read data; holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= mapped ? words[idx] : '0;
    end

    // One-cycle flag for accesses outside the defined offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_unmapped <= 1'b0;
        else        bus_unmapped <= bus_valid & ~mapped;
    end

endmodule

// File: rtl/gpc_checker.sv
// gpc_checker: temporal properties of gpc_companion, bound to every
// instance. Assumes single-cycle bus strobes.
module gpc_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int LINES  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_unmapped,
    input logic [LINES-1:0]  gpio_out,
    input logic [LINES-1:0]  gpio_chg,
    input logic [LINES-1:0]  dir_q,
    input logic [LINES-1:0]  lvl_q
);

    logic port_wr;
    logic lvl_wr;

    // Writes that start an evaluation of the driven vector.
    always_comb begin
        lvl_wr  = bus_valid && bus_write &&
                  (bus_addr == ADDR_W'(12'h024) || bus_addr == ADDR_W'(12'h028));
        port_wr = lvl_wr || (bus_valid && bus_write && bus_addr == ADDR_W'(12'h020));
    end

    assert_out_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_out & ~dir_q) == '0);

    assert_chg_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|gpio_chg) |-> $past(port_wr));

    assert_chg_is_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_out ^ $past(gpio_out)) == gpio_chg);

    assert_level_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr |=> ((lvl_q & ~dir_q) == '0));

    assert_unmapped_after_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_unmapped |-> $past(bus_valid));

    assert_status_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == ADDR_W'(12'h008)) |=>
        (bus_rdata == DATA_W'(16'h0002)));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind gpc_companion gpc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .bus_unmapped (bus_unmapped),
    .gpio_out     (gpio_out),
    .gpio_chg     (gpio_chg),
    .dir_q        (u_gpio.dir_q),
    .lvl_q        (u_gpio.lvl_q)
);

// File: tb/sim_gpc_companion.sv
module sim_gpc_companion;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [15:0] ext_we = '0;
    logic [15:0] ext_val = '0;
    logic [15:0] bus_rdata;
    logic        bus_unmapped;
    logic [15:0] gpio_out;
    logic [15:0] gpio_chg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model state.
    logic [15:0] m_word [11];
    logic [15:0] m_dir, m_lvl, m_out, m_chg, m_rdata;
    logic        m_unm;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpc_companion u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ext_we(ext_we),
        .ext_val(ext_val), .bus_rdata(bus_rdata), .bus_unmapped(bus_unmapped),
        .gpio_out(gpio_out), .gpio_chg(gpio_chg)
    );

    function automatic bit is_mapped(input logic [11:0] a);
        return (a[1:0] == 2'b00) && (a[11:2] < 10'd11);
    endfunction

    function automatic logic [15:0] model_read(input logic [11:0] a);
        if (!is_mapped(a)) return 16'h0000;
        case (int'(a[11:2]))
            2:       return 16'h0002;
            8:       return m_dir;
            9, 10:   return m_lvl;
            default: return m_word[int'(a[11:2])];
        endcase
    endfunction

    function automatic string read_tag(input logic [11:0] a);
        if (!is_mapped(a)) return "R9";
        case (int'(a[11:2]))
            2:       return "R4";
            3:       return "R3";
            9, 10:   return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, update the model, then
    // sample just after the rising edge where every output has settled.
    task automatic step(input logic v, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic [15:0] ew,
                        input logic [15:0] ev);
        logic [15:0] lvl_n, dir_n, wd, eff;
        bit          is_rd, eval, lvl_hit;
        string       rtag;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        ext_we = ew; ext_val = ev;
        wd      = d[15:0];
        is_rd   = v && !w;
        rtag    = read_tag(a);
        m_unm   = v && !is_mapped(a);
        if (is_rd) m_rdata = model_read(a);
        lvl_n   = (m_lvl & ~ew) | (ev & ew);
        dir_n   = m_dir;
        eval    = 1'b0;
        lvl_hit = 1'b0;
        if (v && w && is_mapped(a)) begin
            case (int'(a[11:2]))
                2: ;
                3: m_word[3] = wd[7] ? (wd | 16'h8040) : wd;
                8: begin dir_n = wd; eval = 1'b1; end
                9, 10: begin lvl_n = wd & m_dir; eval = 1'b1; lvl_hit = 1'b1; end
                default: m_word[int'(a[11:2])] = wd;
            endcase
        end
        m_lvl = lvl_n;
        m_dir = dir_n;
        if (eval) begin
            eff   = m_lvl & m_dir;
            m_chg = eff ^ m_out;
            m_out = eff;
        end else begin
            m_chg = '0;
        end
        @(posedge clk);
        #1;
        check(eval ? "R6" : (|ew ? "R8" : "R6"), "gpio_out", gpio_out, m_out);
        check(eval ? "R7" : (|ew ? "R8" : "R7"), "gpio_chg", gpio_chg, m_chg);
        check("R9", "unmapped", {15'd0, bus_unmapped}, {15'd0, m_unm});
        check(is_rd ? rtag : "R10", "rdata", bus_rdata, m_rdata);
        if (lvl_hit && |ew) check("R8", "bus-over-ext level", m_lvl & ~m_dir, 16'h0000);
        bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, 16'h0, 16'h0);
    endtask

    task automatic rd(input logic [11:0] a);
        step(1'b1, 1'b0, a, 32'h0, 16'h0, 16'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 11; i++) m_word[i] = '0;
        m_dir = '0; m_lvl = '0; m_out = '0; m_chg = '0; m_rdata = '0; m_unm = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports.
        check("R1", "rdata", bus_rdata, 16'h0);
        check("R1", "gpio_out", gpio_out, 16'h0);
        check("R1", "gpio_chg", gpio_chg, 16'h0);
        check("R1", "unmapped", {15'd0, bus_unmapped}, 16'h0);
        for (int i = 0; i < 11; i++) rd(12'(i * 4));

        // R2: truncation; R3: power set rule; R4: status write ignored.
        wr(12'h000, 32'h1234_5678); rd(12'h000);
        wr(12'h00C, 32'h0000_0080); rd(12'h00C);
        wr(12'h00C, 32'h0000_0001); rd(12'h00C);
        wr(12'h008, 32'h0000_FFFF); rd(12'h008);
        // R5/R6/R7: masked level, alias offsets, toggle strobes.
        wr(12'h020, 32'h0000_00FF);
        wr(12'h024, 32'h0000_FFFF); rd(12'h028);
        wr(12'h028, 32'h0000_0F0F); rd(12'h024);
        wr(12'h028, 32'h0000_0F0F);
        // R8: external set of an input line, then direction exposes it.
        step(1'b0, 1'b0, 12'h0, 32'h0, 16'h1000, 16'h1000); rd(12'h024);
        wr(12'h020, 32'h0000_F0FF);
        // R8: bus level write and external update in the same cycle.
        step(1'b1, 1'b1, 12'h024, 32'h0, 16'h0001, 16'h0001); rd(12'h024);
        // R9: unmapped offsets; R10: hold across non-reads.
        wr(12'h02C, 32'hFFFF_FFFF); rd(12'h02C);
        rd(12'h002); rd(12'hFFC);
        step(1'b0, 1'b0, 12'h0, 32'h0, 16'h0, 16'h0);

        for (int n = 0; n < N_RANDOM; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic [15:0] ew, ev;
            logic        v, w;
            a  = ($urandom % 5 == 0) ? 12'($urandom % 4096) : 12'(($urandom % 11) * 4);
            d  = $urandom;
            if ($urandom % 3 == 0) d[7] = 1'b1;
            v  = ($urandom % 8) != 0;
            w  = $urandom % 2 == 0;
            ew = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
            ev = 16'($urandom);
            step(v, w, a, d, ew, ev);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule